// File: doc/BRIEF.md
# Serial Memory Program Sequencer

This block carries out the modifying commands of a small serial non-volatile memory once a serial front-end has decoded them. The front-end reports each command as a one-cycle pulse with an operation code and an address, and reports each complete data word as another pulse. The block holds a write-enable latch that gates every modifying command. It gathers page-write data into a buffer whose pointer wraps inside the page. It starts the stored operation only when chip select falls, and it keeps the array unchanged for a programmable number of system-clock cycles before it applies the update. While the operation runs, and after it ends, the block drives a busy/ready level on the serial data output whenever chip select is high.

The array is a register model that resets to the erased state, which is all ones. Reads are combinational from the array and do not depend on the enable latch. A ready level stays visible on every later selection until the front-end reports a start bit.

Top module: `mseq_prog`

## Requirements
- R1: After reset the enable latch is clear, every location reads all ones, and the data output is not driven even with chip select high.
- R2: Operation codes on `cmd_op_i` are 1 write, 2 erase, 3 write-all, 4 erase-all, 5 enable, 6 disable. Enable sets the latch and disable clears it. While the latch is clear, the codes 1 to 4 cause no change and no busy period.
- R3: An accepted operation starts only on the cycle in which chip select is seen falling. A write or write-all that has received no data word does not start. Chip select falling also drops an incomplete command.
- R4: The busy period lasts exactly `PROG_CYCLES` cycles. The array holds its old content during the busy period and takes the new content at its end.
- R5: Erase sets the addressed location to all ones.
- R6: Erase-all sets every location to all ones. Write-all writes the last data word received to every location.
- R7: Page write puts successive data words at successive addresses. Only the low `PAGE_W` address bits advance, wrapping from all ones to zero. A word that passes the page size overwrites the earlier buffered word at that slot. Locations that receive no word keep their content.
- R8: While busy and with chip select high, the output is driven low. With chip select low, the output is not driven.
- R9: When the operation ends, the output is driven high on every selection until a start bit is reported. After that the output is released.
- R10: Commands, data and chip-select edges that arrive during the busy period are ignored. This includes disable.
- R11: `rd_data_o` always returns the stored content of `rd_addr_i`, whatever the state of the enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select level, synchronous to clk |
| start_bit_i | input | 1 | Pulse: a start bit was clocked in |
| cmd_valid_i | input | 1 | Pulse: a decoded command is present |
| cmd_op_i | input | 3 | Operation code (see R2) |
| cmd_addr_i | input | ADDR_W | Command address |
| data_valid_i | input | 1 | Pulse: a complete data word is present |
| data_i | input | DATA_W | Data word |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Stored content at rd_addr_i |
| do_oe_o | output | 1 | Data output driven |
| do_o | output | 1 | Data output level: 0 busy, 1 ready |

## Verification
An operation starts at the first rising edge that sees chip select low. Busy becomes visible after that edge and holds for `PROG_CYCLES` edges. The bench drives inputs at falling edges and samples one time unit later. It counts the low status samples, starting at the falling edge after the launch edge, and expects exactly `PROG_CYCLES` of them followed by a high sample. A start bit clears the ready level at the next rising edge, so the release is checked at the following falling edge. The array is read back through the combinational read port after the ready sample and compared with a model the bench computes itself. One read in the middle of a busy period confirms that the array has not yet changed.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WRAL  = 3'd3,
        OP_ERAL  = 3'd4,
        OP_WEN   = 3'd5,
        OP_WDS   = 3'd6
    } op_e;
endpackage

// File: rtl/mseq_prog_timer.sv
module mseq_prog_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.busy) begin
            if (tm_q.cnt == '0) tm_d.busy = 1'b0;
            else                tm_d.cnt  = tm_q.cnt - 1'b1;
        end else if (start_i) begin
            tm_d.busy = 1'b1;
            tm_d.cnt  = CW'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign busy_o = tm_q.busy;
    assign done_o = tm_q.busy && (tm_q.cnt == '0);

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start_i |-> !busy_o); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o); // R4
endmodule

// File: rtl/mseq_page_buf.sv
module mseq_page_buf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_i,
    input  logic [PAGE_W-1:0]              base_i,
    input  logic                           push_i,
    input  logic [DATA_W-1:0]              data_i,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] buf_o,
    output logic [(1<<PAGE_W)-1:0]         mask_o
);
    localparam int PAGE = 1 << PAGE_W;

    typedef struct packed {
        logic [PAGE-1:0][DATA_W-1:0] data;
        logic [PAGE-1:0]             mask;
        logic [PAGE_W-1:0]           ptr;
    } pb_t;

    pb_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (load_i) begin
            pb_d.mask = '0;
            pb_d.ptr  = base_i;
        end else if (push_i) begin
            pb_d.data[pb_q.ptr] = data_i;
            pb_d.mask[pb_q.ptr] = 1'b1;
            pb_d.ptr            = pb_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign buf_o  = pb_q.data;
    assign mask_o = pb_q.mask;

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) !load_i |=> ((mask_o & $past(mask_o)) == $past(mask_o))); // R7
endmodule

// File: rtl/mseq_status.sv
module mseq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic busy_i,
    input  logic done_i,
    input  logic start_bit_i,
    output logic do_oe_o,
    output logic do_o
);
    logic ready_d, ready_q;

    always_comb begin
        ready_d = ready_q;
        if (done_i)                     ready_d = 1'b1;
        else if (start_bit_i || busy_i) ready_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ready_d;
    end

    assign do_oe_o = cs_i && (busy_i || ready_q);
    assign do_o    = ready_q && !busy_i;

    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (start_bit_i && !done_i) |=> !do_o); // R9
endmodule

// File: rtl/mseq_prog.sv
module mseq_prog
    import mseq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              start_bit_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              do_oe_o,
    output logic              do_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    typedef struct packed {
        logic                         wen;
        logic                         cs;
        op_e                          op;
        logic [ADDR_W-1:0]            addr;
        logic [DATA_W-1:0]            fill;
        logic                         fill_have;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;

    logic                        tm_start, tm_busy, tm_done;
    logic                        pb_load, pb_push;
    logic [PAGE-1:0][DATA_W-1:0] pb_buf;
    logic [PAGE-1:0]             pb_mask;

    mseq_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(tm_start),
        .busy_o(tm_busy), .done_o(tm_done)
    );

    mseq_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst_n(rst_n), .load_i(pb_load),
        .base_i(cmd_addr_i[PAGE_W-1:0]), .push_i(pb_push), .data_i(data_i),
        .buf_o(pb_buf), .mask_o(pb_mask)
    );

    mseq_status u_status (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .busy_i(tm_busy),
        .done_i(tm_done), .start_bit_i(start_bit_i),
        .do_oe_o(do_oe_o), .do_o(do_o)
    );

    always_comb begin
        logic              cs_fall;
        logic              complete;
        logic [ADDR_W-1:0] idx;
        op_e               op_in;

        st_d     = st_q;
        st_d.cs  = cs_i;
        tm_start = 1'b0;
        pb_load  = 1'b0;
        pb_push  = 1'b0;
        cs_fall  = st_q.cs && !cs_i;
        op_in    = op_e'(cmd_op_i);
        idx      = '0;
        complete = (st_q.op == OP_ERASE) || (st_q.op == OP_ERAL) ||
                   ((st_q.op == OP_WRITE) && (|pb_mask)) ||
                   ((st_q.op == OP_WRAL) && st_q.fill_have);

        if (tm_done) begin
            case (st_q.op)
                OP_WRITE: begin
                    for (int i = 0; i < PAGE; i++) begin
                        idx = {st_q.addr[ADDR_W-1:PAGE_W], PAGE_W'(i)};
                        if (pb_mask[i]) st_d.mem[idx] = pb_buf[i];
                    end
                end
                OP_ERASE: st_d.mem[st_q.addr] = '1;
                OP_WRAL: begin
                    for (int j = 0; j < DEPTH; j++) st_d.mem[j] = st_q.fill;
                end
                OP_ERAL: st_d.mem = '1;
                default: ;
            endcase
            st_d.op = OP_NONE;
        end else if (!tm_busy) begin
            if (cmd_valid_i) begin
                case (op_in)
                    OP_WEN: st_d.wen = 1'b1;
                    OP_WDS: st_d.wen = 1'b0;
                    OP_WRITE, OP_ERASE, OP_WRAL, OP_ERAL: begin
                        if (st_q.wen) begin
                            st_d.op        = op_in;
                            st_d.addr      = cmd_addr_i;
                            st_d.fill_have = 1'b0;
                            pb_load        = 1'b1;
                        end else begin
                            st_d.op = OP_NONE;
                        end
                    end
                    default: st_d.op = OP_NONE;
                endcase
            end else if (data_valid_i) begin
                if (st_q.op == OP_WRITE) begin
                    pb_push = 1'b1;
                end else if (st_q.op == OP_WRAL) begin
                    st_d.fill      = data_i;
                    st_d.fill_have = 1'b1;
                end
            end
            if (cs_fall) begin
                if (complete) tm_start = 1'b1;
                else          st_d.op  = OP_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.op   <= OP_NONE;
            st_q.mem  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.mem[rd_addr_i];

    AST_WEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid_i |=> $stable(st_q.wen)); // R2
    AST_ARRAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (tm_busy && !tm_done) |=> $stable(st_q.mem)); // R4
    AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(tm_busy) |-> $past(st_q.cs && !cs_i)); // R3
    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) (tm_busy && cs_i) |-> (do_oe_o && !do_o)); // R8
endmodule

// File: tb/mseq_prog_test.sv
module mseq_prog_test;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int PW    = 4;
    localparam int PROG  = 20;
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0, sb = 1'b0, cv = 1'b0, dv = 1'b0;
    logic [2:0]    cop = '0;
    logic [AW-1:0] cadr = '0, ra = '0;
    logic [DW-1:0] dat = '0;
    logic [DW-1:0] rd;
    logic          oe, dout;

    logic [DW-1:0] rm [DEPTH];
    bit            rwen;
    int            errs = 0, checks = 0;
    bit            finished = 0;

    mseq_prog #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .start_bit_i(sb),
        .cmd_valid_i(cv), .cmd_op_i(cop), .cmd_addr_i(cadr),
        .data_valid_i(dv), .data_i(dat), .rd_addr_i(ra),
        .rd_data_o(rd), .do_oe_o(oe), .do_o(dout)
    );

    always #4 clk = ~clk;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int page_slot(int base_low, int k);
        return (base_low + k) % PAGE;
    endfunction

    task automatic sweep(string req);
        int bad = -1;
        int act = 0, exp = 0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); ra = AW'(a); #1;
            if (rd !== rm[a] && bad < 0) begin bad = a; act = rd; exp = rm[a]; end
        end
        chk(bad < 0, req, $sformatf("array at addr %0d", bad), act, exp);
    endtask

    task automatic send_cmd(int op, int adr);
        @(negedge clk); cv = 1'b1; cop = 3'(op); cadr = AW'(adr);
        @(negedge clk); cv = 1'b0;
    endtask

    task automatic send_data(int d);
        @(negedge clk); dv = 1'b1; dat = DW'(d);
        @(negedge clk); dv = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk); sb = 1'b1;
        @(negedge clk); sb = 1'b0;
    endtask

    task automatic select;
        @(negedge clk); cs = 1'b1;
        pulse_start();
    endtask

    task automatic deselect;
        @(negedge clk); cs = 1'b0;
    endtask

    task automatic poll(output int busy_n, output bit ready);
        busy_n = 0;
        @(negedge clk); cs = 1'b1; #1;
        for (int k = 0; k < PROG + 8; k++) begin
            if (oe && !dout) busy_n++;
            else break;
            @(negedge clk); #1;
        end
        ready = oe && dout;
    endtask

    task automatic run_op(int op, int adr, int n, string req);
        logic [DW-1:0] pb [PAGE];
        bit            pm [PAGE];
        logic [DW-1:0] last = '0;
        bit            go;
        int            busy_n;
        bit            ready;
        for (int i = 0; i < PAGE; i++) pm[i] = 0;
        select();
        send_cmd(op, adr);
        for (int i = 0; i < n; i++) begin
            int d = int'($urandom_range(0, 255));
            int s = page_slot(adr % PAGE, i);
            send_data(d);
            pb[s] = DW'(d); pm[s] = 1; last = DW'(d);
        end
        deselect();
        go = rwen && ((op == 2) || (op == 4) || ((op == 1 || op == 3) && n > 0));
        if (op == 5) rwen = 1;
        if (op == 6) rwen = 0;
        poll(busy_n, ready);
        chk(busy_n == (go ? PROG : 0), req, "busy samples R4 R8", busy_n, go ? PROG : 0);
        if (go) begin
            chk(ready, req, "ready after op R9", int'(ready), 1);
            case (op)
                1: for (int i = 0; i < PAGE; i++)
                       if (pm[i]) rm[(adr / PAGE) * PAGE + i] = pb[i];
                2: rm[adr] = '1;
                3: for (int a = 0; a < DEPTH; a++) rm[a] = last;
                4: for (int a = 0; a < DEPTH; a++) rm[a] = '1;
                default: ;
            endcase
        end
        deselect();
        sweep(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int  bn;
        bit  rdy;
        void'($urandom(32'd11));
        for (int a = 0; a < DEPTH; a++) rm[a] = '1;
        rwen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); cs = 1'b1; #1;
        chk(!oe, "R1", "output driven after reset", int'(oe), 0);
        deselect();
        sweep("R1");

        // R2: write blocked while the latch is clear
        run_op(1, 3, 1, "R2");
        run_op(5, 0, 0, "R2");
        run_op(1, 3, 1, "R2");

        // R9: ready level sticky until a start bit
        @(negedge clk); cs = 1'b1; #1;
        chk(oe && dout, "R9", "ready on reselect", int'(oe && dout), 1);
        @(negedge clk); sb = 1'b1;
        @(negedge clk); sb = 1'b0; #1;
        chk(!oe, "R9", "released after start bit", int'(oe), 0);
        deselect();

        // R5, R6
        run_op(1, 17, 4, "R5");
        run_op(2, 18, 0, "R5");
        run_op(3, 0, 2, "R6");
        run_op(4, 0, 0, "R6");

        // R7: page wrap with overwrite, partial page
        run_op(1, 14, 20, "R7");
        run_op(1, 29, 3, "R7");

        // R3: write with no data never starts
        run_op(1, 5, 0, "R3");
        run_op(3, 0, 0, "R3");

        // R10, R4, R8: traffic during busy
        select();
        send_cmd(2, 14);
        deselect();
        @(negedge clk); cs = 1'b1; ra = AW'(14); #1;
        chk(rd === rm[14], "R4", "array unchanged mid-busy", int'(rd), int'(rm[14]));
        send_cmd(6, 0);
        send_cmd(1, 2);
        send_data(8'h5A);
        @(negedge clk); cs = 1'b0; #1;
        chk(!oe, "R8", "released with cs low", int'(oe), 0);
        @(negedge clk); cs = 1'b1;
        for (int k = 0; k < PROG + 4; k++) begin
            @(negedge clk); #1;
            if (oe && dout) break;
        end
        chk(oe && dout, "R10", "ready after busy traffic", int'(oe && dout), 1);
        rm[14] = '1;
        deselect();
        sweep("R10");
        run_op(1, 2, 1, "R10");

        // R11: reads after disable
        run_op(6, 0, 0, "R11");
        run_op(2, 2, 0, "R11");

        // random mix
        for (int t = 0; t < 40; t++) begin
            int op = int'($urandom_range(1, 6));
            int ad = int'($urandom_range(0, DEPTH - 1));
            int n  = int'($urandom_range(0, 20));
            if (op == 5 || op == 6 || op == 2 || op == 4) n = 0;
            run_op(op, ad, n, "R7");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule